// File: doc/BRIEF.md
# Grouped Event Performance Monitor

This block is a register-mapped performance monitor. It holds a set of 32-bit event counters, and the counters are divided into equal groups. Each counter picks one line from a vector of single-cycle event pulses and adds one on every cycle that line is high. Counting only happens when three enables are all set: a global run bit, the enable of the counter's group, and the counter's own enable.

Software uses a simple single-cycle register bus to control the block. The per-counter enables, interrupt enables and overflow flags are packed 32 to a word. Enables are changed through separate set and clear addresses. Overflow flags are cleared by writing 1 to them. A counter that rolls over from all ones to zero raises its overflow flag. The interrupt output is high while any flagged counter also has its interrupt enabled.

Top module: `evmon_top`

## Requirements
- R1: After reset, every counter, select, enable, interrupt enable, overflow flag and the run bit read as 0, and irq is low.
- R2: Address 0x004 is read-only and returns the group count in bits 31:24 and the counter count in bits 7:0. Group g's control word is at 0x010+4g. Its bit 11 is the group enable, and bits 27:24 read back the number of counters in each group.
- R3: Counter n adds one on an edge only if all of these hold: the run bit (bit 0 of the control word at 0x000) is 1, the enable of group n/(counters per group) is 1, the enable of counter n is 1, and its selected event line is high. Otherwise it holds its value.
- R4: The select register of counter n is at 0x400+4n. Its low bits pick which event_in line counter n watches, and it reads back the value written.
- R5: Counter enables are set at 0x040+4w and cleared at 0x060+4w. Counter n maps to word w=n/32, bit n%32. A 1 bit sets or clears that enable and a 0 bit leaves it alone. Both addresses read the current enable mask.
- R6: Writing 1 to bit 1 of the control word zeroes every counter on that edge. The bit reads back as 0, and bit 0 of the same write still sets the run bit.
- R7: When a counter passes from 0xFFFFFFFF to 0, its overflow flag sets. The flags are read at 0x0C0+4w and cleared by writing 1 to a bit. Writing 0 has no effect. If a rollover and a clear of the same bit fall on the same edge, the flag stays set.
- R8: Interrupt enables are set at 0x080+4w and cleared at 0x0A0+4w, and both addresses read the mask. irq is high exactly when some counter has both its overflow flag and its interrupt enable set.
- R9: The count of counter n is at 0x800+4n. A write loads that value, and the write takes priority over an increment on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| event_in | input | NUM_EVT | One-cycle event pulses |
| irq | output | 1 | Level overflow interrupt |

## Verification
The following take effect on the first rising edge after they are presented, and read back as soon as that edge has passed:
- register writes, including counter loads, the zeroing command and overflow clears;
- event pulses, which become visible in the counts at the same point.

A rollover sets its flag on the same edge that the count becomes zero. irq is decoded combinationally from the registered masks, so it follows that same edge. Read data is combinational from the address with no added cycle. The bench drives every input just after a falling edge and samples the outputs 2 ns later. It updates its reference model at each rising edge, so expected and actual values always refer to the same edge.

// File: rtl/evmon_pkg.sv
package evmon_pkg;
    localparam int CNT_W = 32;

    localparam logic [11:0] A_CTRL   = 12'h000;
    localparam logic [11:0] A_CFG    = 12'h004;
    localparam logic [11:0] A_ENSET  = 12'h040;
    localparam logic [11:0] A_ENCLR  = 12'h060;
    localparam logic [11:0] A_INTSET = 12'h080;
    localparam logic [11:0] A_INTCLR = 12'h0A0;
    localparam logic [11:0] A_OVF    = 12'h0C0;

    localparam int CTRL_RUN_BIT  = 0;
    localparam int CTRL_ZERO_BIT = 1;
    localparam int GRP_RUN_BIT   = 11;
    localparam int GRP_SIZE_LSB  = 24;
endpackage

// File: rtl/evmon_mask_bank.sv
module evmon_mask_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] bits;
    } mask_st_t;

    mask_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.bits = (st_q.bits & ~clr_i) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o = st_q.bits;

    // R5 R7 R8
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((q_o & $past(set_i)) == $past(set_i)));

    // R5 R7 R8
    mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~set_i) != '0) |=> ((q_o & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/evmon_counter.sv
module evmon_counter #(
    parameter int CNT_W   = 32,
    parameter int NUM_EVT = 16,
    parameter int SEL_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] event_i,
    input  logic               cnt_on_i,
    input  logic               zero_i,
    input  logic               load_i,
    input  logic [CNT_W-1:0]   load_val_i,
    input  logic               sel_we_i,
    input  logic [SEL_W-1:0]   sel_val_i,
    output logic [CNT_W-1:0]   count_o,
    output logic [SEL_W-1:0]   sel_o,
    output logic               wrap_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [SEL_W-1:0] sel;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    evt_seen;
    logic    bump;

    always_comb begin
        evt_seen = (int'(st_q.sel) < NUM_EVT) ? event_i[st_q.sel] : 1'b0;
        bump     = cnt_on_i & evt_seen;
        st_d     = st_q;
        if (zero_i)      st_d.cnt = '0;
        else if (load_i) st_d.cnt = load_val_i;
        else if (bump)   st_d.cnt = st_q.cnt + 1'b1;
        if (sel_we_i)    st_d.sel = sel_val_i;
        wrap_o = bump & ~zero_i & ~load_i & (&st_q.cnt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.cnt;
    assign sel_o   = st_q.sel;

    // R3
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_on_i && !zero_i && !load_i) |=> $stable(count_o));

    // R6
    cnt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zero_i |=> (count_o == '0));

    // R9
    cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !zero_i) |=> (count_o == $past(load_val_i)));

    // R7
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (count_o == '0));
endmodule

// File: rtl/evmon_top.sv
module evmon_top #(
    parameter int NUM_CNT = 8,
    parameter int NUM_GRP = 2,
    parameter int NUM_EVT = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_en,
    input  logic               bus_we,
    input  logic [11:0]        bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_EVT-1:0] event_in,
    output logic               irq
);
    import evmon_pkg::*;

    localparam int PER_GRP = NUM_CNT / NUM_GRP;
    localparam int SEL_W   = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;

    typedef struct packed {
        logic               run;
        logic [NUM_GRP-1:0] grp_run;
    } ctl_st_t;

    ctl_st_t ctl_d, ctl_q;

    logic               wr, aligned;
    logic               hit_ctrl, hit_cfg, hit_grp, hit_evt, hit_cnt;
    logic               hit_enset, hit_enclr, hit_iset, hit_iclr, hit_ovf;
    int                 grp_idx, word_idx, cnt_idx;
    logic [NUM_CNT-1:0] spread;
    logic [NUM_CNT-1:0] en_set, en_clr, ie_set, ie_clr, ovf_clr;
    logic [NUM_CNT-1:0] en_q, ie_q, ovf_q, wrap_v, word_src;
    logic               zero_all;
    logic [CNT_W-1:0]   cnt_v [NUM_CNT];
    logic [SEL_W-1:0]   sel_v [NUM_CNT];

    // Address decode
    always_comb begin
        wr        = bus_en & bus_we;
        aligned   = (bus_addr[1:0] == 2'b00);
        hit_ctrl  = aligned && (bus_addr == A_CTRL);
        hit_cfg   = aligned && (bus_addr == A_CFG);
        hit_grp   = aligned && (bus_addr[11:6] == 6'd0) && (bus_addr[5:4] != 2'd0);
        hit_enset = aligned && (bus_addr[11:5] == A_ENSET[11:5]);
        hit_enclr = aligned && (bus_addr[11:5] == A_ENCLR[11:5]);
        hit_iset  = aligned && (bus_addr[11:5] == A_INTSET[11:5]);
        hit_iclr  = aligned && (bus_addr[11:5] == A_INTCLR[11:5]);
        hit_ovf   = aligned && (bus_addr[11:5] == A_OVF[11:5]);
        hit_evt   = aligned && (bus_addr[11:10] == 2'b01);
        hit_cnt   = aligned && (bus_addr[11:10] == 2'b10);
        grp_idx   = int'(bus_addr[5:2]) - 4;
        word_idx  = int'(bus_addr[4:2]);
        cnt_idx   = int'(bus_addr[9:2]);
        for (int n = 0; n < NUM_CNT; n++) begin
            spread[n] = ((n / 32) == word_idx) ? bus_wdata[n % 32] : 1'b0;
        end
        en_set   = (wr && hit_enset) ? spread : '0;
        en_clr   = (wr && hit_enclr) ? spread : '0;
        ie_set   = (wr && hit_iset)  ? spread : '0;
        ie_clr   = (wr && hit_iclr)  ? spread : '0;
        ovf_clr  = (wr && hit_ovf)   ? spread : '0;
        zero_all = wr && hit_ctrl && bus_wdata[CTRL_ZERO_BIT];
    end

    // Global and group run bits
    always_comb begin
        ctl_d = ctl_q;
        if (wr && hit_ctrl) ctl_d.run = bus_wdata[CTRL_RUN_BIT];
        for (int g = 0; g < NUM_GRP; g++) begin
            if (wr && hit_grp && (grp_idx == g)) ctl_d.grp_run[g] = bus_wdata[GRP_RUN_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    evmon_mask_bank #(.W(NUM_CNT)) u_en (
        .clk(clk), .rst_n(rst_n), .set_i(en_set), .clr_i(en_clr), .q_o(en_q));

    evmon_mask_bank #(.W(NUM_CNT)) u_ie (
        .clk(clk), .rst_n(rst_n), .set_i(ie_set), .clr_i(ie_clr), .q_o(ie_q));

    evmon_mask_bank #(.W(NUM_CNT)) u_ovf (
        .clk(clk), .rst_n(rst_n), .set_i(wrap_v), .clr_i(ovf_clr), .q_o(ovf_q));

    for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt
        logic cnt_on;
        assign cnt_on = ctl_q.run & ctl_q.grp_run[n / PER_GRP] & en_q[n];
        evmon_counter #(.CNT_W(CNT_W), .NUM_EVT(NUM_EVT), .SEL_W(SEL_W)) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .event_i   (event_in),
            .cnt_on_i  (cnt_on),
            .zero_i    (zero_all),
            .load_i    (wr && hit_cnt && (cnt_idx == n)),
            .load_val_i(bus_wdata),
            .sel_we_i  (wr && hit_evt && (cnt_idx == n)),
            .sel_val_i (bus_wdata[SEL_W-1:0]),
            .count_o   (cnt_v[n]),
            .sel_o     (sel_v[n]),
            .wrap_o    (wrap_v[n])
        );
    end

    assign irq = |(ovf_q & ie_q);

    // Read mux
    always_comb begin
        bus_rdata = '0;
        word_src  = '0;
        if (hit_enset || hit_enclr)    word_src = en_q;
        else if (hit_iset || hit_iclr) word_src = ie_q;
        else if (hit_ovf)              word_src = ovf_q;
        if (hit_ctrl) begin
            bus_rdata[CTRL_RUN_BIT] = ctl_q.run;
        end else if (hit_cfg) begin
            bus_rdata[31:24] = 8'(NUM_GRP);
            bus_rdata[7:0]   = 8'(NUM_CNT);
        end else if (hit_grp) begin
            for (int g = 0; g < NUM_GRP; g++) begin
                if (grp_idx == g) begin
                    bus_rdata[GRP_RUN_BIT] = ctl_q.grp_run[g];
                    bus_rdata[GRP_SIZE_LSB +: 4] = 4'(PER_GRP);
                end
            end
        end else if (hit_enset || hit_enclr || hit_iset || hit_iclr || hit_ovf) begin
            for (int n = 0; n < NUM_CNT; n++) begin
                if ((n / 32) == word_idx) bus_rdata[n % 32] = word_src[n];
            end
        end else if (hit_evt) begin
            for (int n = 0; n < NUM_CNT; n++) begin
                if (cnt_idx == n) bus_rdata[SEL_W-1:0] = sel_v[n];
            end
        end else if (hit_cnt) begin
            for (int n = 0; n < NUM_CNT; n++) begin
                if (cnt_idx == n) bus_rdata = cnt_v[n];
            end
        end
    end

    // R8
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_q == '0) |-> !irq);

    // R6
    zero_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zero_all |=> (ctl_q.run == $past(bus_wdata[CTRL_RUN_BIT])));
endmodule

// File: tb/evmon_top_tb_top.sv
`timescale 1ns/1ps
module evmon_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [15:0] event_in = '0;
    logic        irq;

    evmon_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .event_in(event_in), .irq(irq));

    always #5 clk = ~clk;

    int total = 0, bad = 0;
    bit done = 1'b0;

    logic [31:0] m_cnt [8];
    logic [3:0]  m_sel [8];
    logic [7:0]  m_en = '0, m_ie = '0, m_ov = '0;
    logic        m_run = 1'b0;
    logic [1:0]  m_grp = '0;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic model_step(input logic [15:0] ev, input bit w, input logic [11:0] a,
                              input logic [31:0] d);
        logic [7:0] wrap = '0;
        for (int n = 0; n < 8; n++) begin
            bit hit = m_run & m_grp[n/4] & m_en[n] & ev[m_sel[n]];
            if (w && a == 12'h000 && d[1]) m_cnt[n] = '0;
            else if (w && a == 12'(12'h800 + 4*n)) m_cnt[n] = d;
            else if (hit) begin
                if (m_cnt[n] == 32'hFFFF_FFFF) begin
                    m_cnt[n] = '0;
                    wrap[n] = 1'b1;
                end else m_cnt[n] = m_cnt[n] + 1;
            end
        end
        if (w) begin
            case (a)
                12'h000: m_run = d[0];
                12'h010: m_grp[0] = d[11];
                12'h014: m_grp[1] = d[11];
                12'h040: m_en = m_en | d[7:0];
                12'h060: m_en = m_en & ~d[7:0];
                12'h080: m_ie = m_ie | d[7:0];
                12'h0A0: m_ie = m_ie & ~d[7:0];
                12'h0C0: m_ov = m_ov & ~d[7:0];
                default: if (a >= 12'h400 && a < 12'h420) m_sel[(a - 12'h400) >> 2] = d[3:0];
            endcase
        end
        m_ov = m_ov | wrap;
    endtask

    task automatic tick(input logic [15:0] ev, input bit w, input logic [11:0] a,
                        input logic [31:0] d);
        @(negedge clk);
        event_in = ev; bus_en = w; bus_we = w; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        model_step(ev, w, a, d);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        tick(16'h0, 1'b1, a, d);
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        @(negedge clk);
        event_in = '0; bus_en = 1'b1; bus_we = 1'b0; bus_addr = a; bus_wdata = '0;
        #2 v = bus_rdata;
    endtask

    task automatic compare_all(input string req);
        logic [31:0] v;
        for (int n = 0; n < 8; n++) begin
            rd(12'(12'h800 + 4*n), v);
            chk(req, v, m_cnt[n]);
        end
        rd(12'h0C0, v);
        chk({req, " R7 flags"}, v, {24'h0, m_ov});
        chk({req, " R8 irq"}, {31'h0, irq}, {31'h0, |(m_ov & m_ie)});
    endtask

    initial begin
        logic [31:0] v;
        void'($urandom(32'd4242));
        for (int n = 0; n < 8; n++) begin m_cnt[n] = '0; m_sel[n] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        chk("R1 irq", {31'h0, irq}, 32'h0);
        rd(12'h000, v); chk("R1 ctrl", v, 32'h0);
        rd(12'h040, v); chk("R1 enables", v, 32'h0);
        rd(12'h804, v); chk("R1 count", v, 32'h0);
        // R2 configuration words
        rd(12'h004, v); chk("R2 cfg", v, 32'h0200_0008);
        rd(12'h014, v); chk("R2 group size", v, 32'h0400_0000);

        // R5 set/clear pair
        wr(12'h040, 32'h05);
        rd(12'h040, v); chk("R5 set", v, 32'h05);
        rd(12'h060, v); chk("R5 read via clear", v, 32'h05);
        wr(12'h040, 32'h00);
        rd(12'h040, v); chk("R5 zero set ignored", v, 32'h05);
        wr(12'h060, 32'h04);
        rd(12'h060, v); chk("R5 clear", v, 32'h01);
        wr(12'h060, 32'h00);
        rd(12'h040, v); chk("R5 zero clear ignored", v, 32'h01);

        // R3 three-level gating
        for (int n = 0; n < 8; n++) wr(12'(12'h400 + 4*n), 32'(n));
        wr(12'h040, 32'hFF);
        repeat (3) tick(16'hFFFF, 1'b0, 12'h0, 32'h0);
        compare_all("R3 global off");
        wr(12'h000, 32'h1);
        repeat (3) tick(16'hFFFF, 1'b0, 12'h0, 32'h0);
        compare_all("R3 groups off");
        wr(12'h010, 32'h800);
        repeat (2) tick(16'hFFFF, 1'b0, 12'h0, 32'h0);
        rd(12'h800, v); chk("R3 group0 counts", v, 32'd2);
        rd(12'h810, v); chk("R3 group1 idle", v, 32'd0);
        wr(12'h060, 32'h02);
        tick(16'hFFFF, 1'b0, 12'h0, 32'h0);
        compare_all("R3 counter off");

        // R4 event select
        wr(12'h014, 32'h800);
        wr(12'h418, 32'h2);
        rd(12'h418, v); chk("R4 select readback", v, 32'h2);
        tick(16'h0004, 1'b0, 12'h0, 32'h0);
        compare_all("R4 select");

        // R9 load
        wr(12'h808, 32'h1234_5678);
        rd(12'h808, v); chk("R9 load", v, 32'h1234_5678);
        tick(16'h0004, 1'b1, 12'h808, 32'hABCD_0000);
        rd(12'h808, v); chk("R9 load beats increment", v, 32'hABCD_0000);

        // R7 rollover, R8 interrupt
        wr(12'h800, 32'hFFFF_FFFE);
        tick(16'h0001, 1'b0, 12'h0, 32'h0);
        rd(12'h0C0, v); chk("R7 no flag before wrap", v, 32'h0);
        tick(16'h0001, 1'b0, 12'h0, 32'h0);
        rd(12'h800, v); chk("R7 wrapped count", v, 32'h0);
        rd(12'h0C0, v); chk("R7 flag set", v, 32'h1);
        chk("R8 masked irq", {31'h0, irq}, 32'h0);
        wr(12'h080, 32'h1);
        rd(12'h0A0, v); chk("R8 read via clear", v, 32'h1);
        chk("R8 irq raised", {31'h0, irq}, 32'h1);
        wr(12'h0C0, 32'h0);
        rd(12'h0C0, v); chk("R7 zero write ignored", v, 32'h1);
        wr(12'h0C0, 32'h1);
        rd(12'h0C0, v); chk("R7 cleared", v, 32'h0);
        chk("R8 irq dropped", {31'h0, irq}, 32'h0);
        wr(12'h800, 32'hFFFF_FFFF);
        tick(16'h0001, 1'b1, 12'h0C0, 32'h1);
        rd(12'h0C0, v); chk("R7 wrap beats clear", v, 32'h1);
        chk("R8 irq after race", {31'h0, irq}, 32'h1);

        // R6 zero all
        wr(12'h80C, 32'd77);
        wr(12'h000, 32'h3);
        rd(12'h000, v); chk("R6 bit self-clears", v, 32'h1);
        compare_all("R6 zeroed");

        // Random phase
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] ev = 16'($urandom);
            if ($urandom_range(0, 7) == 0) begin
                logic [11:0] a;
                logic [31:0] d = $urandom;
                case ($urandom_range(0, 9))
                    0: begin a = 12'h000; d = {30'h0, ($urandom_range(0, 15) == 0), ($urandom_range(0, 5) != 0)}; end
                    1: a = 12'(12'h010 + 4*$urandom_range(0, 1));
                    2: a = 12'h040;
                    3: a = 12'h060;
                    4: a = 12'h080;
                    5: a = 12'h0A0;
                    6: a = 12'h0C0;
                    7: a = 12'(12'h400 + 4*$urandom_range(0, 7));
                    default: begin a = 12'(12'h800 + 4*$urandom_range(0, 7)); d = 32'hFFFF_FFF0 + 32'($urandom_range(0, 15)); end
                endcase
                tick(ev, 1'b1, a, d);
            end else begin
                tick(ev, 1'b0, 12'h0, 32'h0);
            end
            if (i % 60 == 59) compare_all("R3 R4 R7 R8 random");
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1_900_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired got=running exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule